// File: doc/BRIEF.md
# VM Operand Fetch and Address Generation

This block sits between instruction decode and execution in a virtual-machine core whose instructions are 128 bits wide. It holds the eight 64-bit integer registers and, for every accepted instruction, produces three things: a scratchpad byte read address for operand A, the operand-B value, and a sign-extended write-address mask for operand C. The execution stage writes results back into the register file through a dedicated port.

Forming the operand-A address has a side effect on architectural state. The register named by the A index is replaced by its value XOR a sign-extended 32-bit mask from the instruction. The low W bits of the new value, scaled by eight, become an 8-byte aligned read address. Operand B comes from a register or from an immediate, as chosen by a 3-bit location code. A shift-class flag picks the 8-bit immediate or the 32-bit immediate.

The control is a two-state machine. ST_IDLE means no result is presented. ST_OUT means the output registers hold the result of the instruction accepted on the previous edge. Transition IDLE_TO_OUT happens when in_valid is high in ST_IDLE. OUT_TO_OUT happens when in_valid stays high in ST_OUT. OUT_TO_IDLE happens when in_valid is low in ST_OUT. IDLE_TO_IDLE happens when in_valid stays low in ST_IDLE. The result registers keep their last values whenever no instruction is accepted.

Top module: `vm_operand_fetch`

## Requirements
- R1: After reset, out_valid is 0 and all eight registers read as zero.
- R2: Instruction fields use these bit positions: A index [10:8], B location code [18:16], B index [26:24], C index [34:32], 8-bit immediate [47:40], A mask [79:48], 32-bit immediate [111:80]. All other bits are ignored.
- R3: On an edge where in_valid is 1, register A becomes its old value XOR the A mask sign-extended to 64 bits.
- R4: On the edge after acceptance, rd_addr (W+3 bits) equals the low W bits of the updated register A, shifted left by 3.
- R5: Location codes 000 to 101 give op_b = register B and b_is_imm = 0. The register value is the one held before the accepting edge, even when the B index equals the A index.
- R6: Location codes 110 and 111 with shift_class = 1 give op_b = the 8-bit immediate zero-extended, with b_is_imm = 1.
- R7: Location codes 110 and 111 with shift_class = 0 give op_b = the 32-bit immediate sign-extended to 64 bits, with b_is_imm = 1.
- R8: wr_mask is the 32-bit immediate sign-extended to 64 bits, and c_idx is the C index.
- R9: wb_en = 1 writes wb_data into register wb_idx. If it targets the same register as an operand-A update on the same edge, the operand-A update wins.
- R10: out_valid is 1 exactly on the cycle after each edge with in_valid = 1. While in_valid is 0, rd_addr, op_b, b_is_imm, wr_mask and c_idx hold their values.
- R11: With in_valid = 0 and wb_en = 0, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Accept instr on this edge |
| instr | input | 128 | Decoded instruction word |
| shift_class | input | 1 | Operation uses 8-bit immediate for B |
| wb_en | input | 1 | Result write-back enable |
| wb_idx | input | 3 | Result write-back register index |
| wb_data | input | 64 | Result write-back value |
| out_valid | output | 1 | Results present |
| rd_addr | output | W+3 | Scratchpad byte read address for A |
| op_b | output | 64 | Operand B value |
| b_is_imm | output | 1 | Operand B came from an immediate |
| wr_mask | output | 64 | Sign-extended write-address mask for C |
| c_idx | output | 3 | Register index for C address |

## Verification
Two functions can act in the same cycle: the operand-A register update and a result write-back to the same register. The same update also meets an operand-B read of that register. The bench issues instructions where the A index equals the B index and checks that op_b shows the value from before the update. Another instruction then reads the register through operand B to confirm the update took place. It also raises wb_en on the A register in the accepting cycle, and a later read must show the XOR-updated value, not wb_data.

// File: rtl/vof_pkg.sv
`timescale 1ns/1ps
package vof_pkg;
    localparam int XLEN    = 64;
    localparam int NREG    = 8;
    localparam int IDXW    = $clog2(NREG);
    localparam int INSTR_W = 128;

    // byte-aligned field offsets
    localparam int RA_LSB    = 8;
    localparam int BSEL_LSB  = 16;
    localparam int RB_LSB    = 24;
    localparam int RC_LSB    = 32;
    localparam int IMM8_LSB  = 40;
    localparam int AMASK_LSB = 48;
    localparam int IMM32_LSB = 80;

    typedef enum logic {ST_IDLE, ST_OUT} vof_state_e;

    typedef struct packed {
        logic [IDXW-1:0] ra;
        logic [2:0]      bsel;
        logic [IDXW-1:0] rb;
        logic [IDXW-1:0] rc;
        logic [7:0]      imm8;
        logic [31:0]     amask;
        logic [31:0]     imm32;
    } vof_fields_t;

    function automatic logic [XLEN-1:0] sext32(input logic [31:0] v);
        return {{(XLEN-32){v[31]}}, v};
    endfunction
endpackage

// File: rtl/vof_decode.sv
`timescale 1ns/1ps
module vof_decode
    import vof_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output vof_fields_t        fld
);
    always_comb begin
        fld.ra    = instr[RA_LSB    +: IDXW];
        fld.bsel  = instr[BSEL_LSB  +: 3];
        fld.rb    = instr[RB_LSB    +: IDXW];
        fld.rc    = instr[RC_LSB    +: IDXW];
        fld.imm8  = instr[IMM8_LSB  +: 8];
        fld.amask = instr[AMASK_LSB +: 32];
        fld.imm32 = instr[IMM32_LSB +: 32];
    end
endmodule

// File: rtl/vof_regfile.sv
`timescale 1ns/1ps
module vof_regfile #(
    parameter int N    = 8,
    parameter int XW   = 64,
    localparam int IW  = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] rd_idx_a,
    input  logic [IW-1:0] rd_idx_b,
    output logic [XW-1:0] rd_a,
    output logic [XW-1:0] rd_b,
    input  logic          upd_en,
    input  logic [IW-1:0] upd_idx,
    input  logic [XW-1:0] upd_val,
    input  logic          ext_en,
    input  logic [IW-1:0] ext_idx,
    input  logic [XW-1:0] ext_data
);
    logic [XW-1:0] mem [N];

    for (genvar i = 0; i < N; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[i] <= '0;
            else if (upd_en && upd_idx == IW'(i))
                mem[i] <= upd_val;   // operand-A update has priority
            else if (ext_en && ext_idx == IW'(i))
                mem[i] <= ext_data;
        end

        // R11: untouched without any write source
        a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (!upd_en && !ext_en) |=> $stable(mem[i]));

        // R9: update beats write-back on collision
        a_r9_collide: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_en && ext_en && upd_idx == IW'(i) && ext_idx == IW'(i))
            |=> mem[i] == $past(upd_val));
    end

    assign rd_a = mem[rd_idx_a];
    assign rd_b = mem[rd_idx_b];
endmodule

// File: rtl/vof_bsel.sv
`timescale 1ns/1ps
module vof_bsel #(
    parameter int XW = 64
) (
    input  logic [2:0]    code,
    input  logic          shift_class,
    input  logic [XW-1:0] reg_val,
    input  logic [7:0]    imm8,
    input  logic [31:0]   imm32,
    output logic [XW-1:0] op_b,
    output logic          is_imm
);
    always_comb begin
        is_imm = (code[2:1] == 2'b11);
        if (!is_imm)
            op_b = reg_val;
        else if (shift_class)
            op_b = {{(XW-8){1'b0}}, imm8};
        else
            op_b = {{(XW-32){imm32[31]}}, imm32};
    end
endmodule

// File: rtl/vm_operand_fetch.sv
`timescale 1ns/1ps
module vm_operand_fetch
    import vof_pkg::*;
#(
    parameter int W   = 16,
    localparam int AW = W + 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [127:0]       instr,
    input  logic               shift_class,
    input  logic               wb_en,
    input  logic [2:0]         wb_idx,
    input  logic [63:0]        wb_data,
    output logic               out_valid,
    output logic [AW-1:0]      rd_addr,
    output logic [63:0]        op_b,
    output logic               b_is_imm,
    output logic [63:0]        wr_mask,
    output logic [2:0]         c_idx
);
    vof_state_e  state, state_nx;
    vof_fields_t fld;
    logic [XLEN-1:0] ra_val, rb_val, ra_new, b_nx;
    logic            b_imm_nx;

    vof_decode u_dec (.instr(instr), .fld(fld));

    assign ra_new = ra_val ^ sext32(fld.amask);

    vof_regfile #(.N(NREG), .XW(XLEN)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .rd_idx_a(fld.ra), .rd_idx_b(fld.rb),
        .rd_a(ra_val), .rd_b(rb_val),
        .upd_en(in_valid), .upd_idx(fld.ra), .upd_val(ra_new),
        .ext_en(wb_en), .ext_idx(wb_idx), .ext_data(wb_data)
    );

    vof_bsel #(.XW(XLEN)) u_bsel (
        .code(fld.bsel), .shift_class(shift_class), .reg_val(rb_val),
        .imm8(fld.imm8), .imm32(fld.imm32),
        .op_b(b_nx), .is_imm(b_imm_nx)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (in_valid) state_nx = ST_OUT;   // IDLE_TO_OUT
            ST_OUT:  if (!in_valid) state_nx = ST_IDLE; // OUT_TO_IDLE
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_addr  <= '0;
            op_b     <= '0;
            b_is_imm <= 1'b0;
            wr_mask  <= '0;
            c_idx    <= '0;
        end else if (in_valid) begin
            rd_addr  <= {ra_new[W-1:0], 3'b000};
            op_b     <= b_nx;
            b_is_imm <= b_imm_nx;
            wr_mask  <= sext32(fld.imm32);
            c_idx    <= fld.rc;
        end
    end

    assign out_valid = (state == ST_OUT);

    a_r10_rise: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r10_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(op_b) && $stable(rd_addr) && $stable(wr_mask)));
    a_r8_mask: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> wr_mask[31:0] == $past(instr[111:80]));
    a_r6_zext: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && shift_class && instr[18:17] == 2'b11) |=> op_b[63:8] == '0);
endmodule

// File: tb/vm_operand_fetch_bench.sv
`timescale 1ns/1ps
module vm_operand_fetch_bench;
    localparam int W  = 16;
    localparam int AW = W + 3;

    logic clk = 0, rst_n = 0, in_valid = 0, shift_class = 0, wb_en = 0;
    logic [127:0] instr = '0;
    logic [2:0]   wb_idx = '0;
    logic [63:0]  wb_data = '0;
    logic         out_valid, b_is_imm;
    logic [AW-1:0] rd_addr;
    logic [63:0]  op_b, wr_mask;
    logic [2:0]   c_idx;

    always #2 clk = ~clk;

    vm_operand_fetch #(.W(W)) u_vm_operand_fetch (.*);

    typedef struct {
        logic [AW-1:0] addr;
        logic [63:0]   b;
        logic          bimm;
        logic [63:0]   mask;
        logic [2:0]    c;
        string         tag;
    } exp_t;

    exp_t q[$];
    logic [63:0] model [8];
    int checks = 0, errors = 0;
    bit done = 0;

    function automatic logic [63:0] sx(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: one instruction per call, optional write-back in the same cycle
    task automatic issue(input logic [2:0] ra, input logic [2:0] code, input logic [2:0] rb,
                         input logic [2:0] rc, input logic [7:0] i8, input logic [31:0] am,
                         input logic [31:0] i32, input bit shf, input bit we,
                         input logic [2:0] widx, input logic [63:0] wdat, input string tag);
        exp_t e;
        logic [127:0] ins;
        logic [63:0]  anew;
        ins = {128{1'b1}};                 // ignored bits set to ones (R2)
        ins[10:8] = ra; ins[18:16] = code; ins[26:24] = rb; ins[34:32] = rc;
        ins[47:40] = i8; ins[79:48] = am; ins[111:80] = i32;
        @(negedge clk);
        instr = ins; in_valid = 1; shift_class = shf;
        wb_en = we; wb_idx = widx; wb_data = wdat;
        anew = model[ra] ^ sx(am);
        e.addr = {anew[W-1:0], 3'b000};
        e.bimm = (code[2:1] == 2'b11);
        e.b    = !e.bimm ? model[rb] : (shf ? {56'd0, i8} : sx(i32));
        e.mask = sx(i32);
        e.c    = rc;
        e.tag  = tag;
        if (we) model[widx] = wdat;
        model[ra] = anew;
        q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 0; wb_en = 0;
    endtask

    task automatic wb(input logic [2:0] idx, input logic [63:0] d);
        @(negedge clk);
        in_valid = 0; wb_en = 1; wb_idx = idx; wb_data = d;
        model[idx] = d;
    endtask

    // monitor
    initial begin
        exp_t e;
        logic v;
        forever begin
            @(posedge clk);
            v = in_valid & rst_n;
            #1;
            if (rst_n) begin
                chk(out_valid == v, "R10 out_valid", 64'(out_valid), 64'(v));
                if (v) begin
                    if (q.size() == 0) chk(0, "R10 unexpected result", 0, 0);
                    else begin
                        e = q.pop_front();
                        chk(rd_addr == e.addr, {e.tag, " R4 rd_addr"}, 64'(rd_addr), 64'(e.addr));
                        chk(op_b == e.b, {e.tag, " op_b"}, op_b, e.b);
                        chk(b_is_imm == e.bimm, {e.tag, " b_is_imm"}, 64'(b_is_imm), 64'(e.bimm));
                        chk(wr_mask == e.mask, {e.tag, " R8 wr_mask"}, wr_mask, e.mask);
                        chk(c_idx == e.c, {e.tag, " R8 c_idx"}, 64'(c_idx), 64'(e.c));
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        #(4 * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] hb;
        logic [AW-1:0] ha;
        for (int i = 0; i < 8; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1 chk(out_valid == 0, "R1 out_valid after reset", 64'(out_valid), 0);
        // R1: every register reads zero (zero mask leaves it alone)
        for (int i = 0; i < 8; i++)
            issue(3'(i), 3'b000, 3'(i), 3'(i), 8'h00, 32'h0, 32'h0, 0, 0, 0, 0, "R1 reg zero");
        idle();
        // R9: load registers through write-back
        for (int i = 0; i < 8; i++) wb(3'(i), 64'h1111_0000_0000_0000 * (i + 1) + 64'h0123_4567 * i);
        idle();
        // R3/R4: positive and negative masks; R5 reads each code 000..101
        issue(3'd1, 3'b000, 3'd2, 3'd5, 8'h12, 32'h0000_1234, 32'h7fff_0000, 0, 0, 0, 0, "R3 pos mask R5 code0");
        issue(3'd1, 3'b001, 3'd1, 3'd6, 8'h34, 32'h8000_00f0, 32'h8000_0001, 0, 0, 0, 0, "R3 neg mask R5 a==b");
        issue(3'd3, 3'b010, 3'd1, 3'd7, 8'h00, 32'hffff_ffff, 32'h0, 0, 0, 0, 0, "R5 code2 sees update");
        issue(3'd4, 3'b011, 3'd4, 3'd0, 8'h00, 32'h0000_8000, 32'h1, 1, 0, 0, 0, "R5 code3 a==b");
        issue(3'd4, 3'b100, 3'd4, 3'd1, 8'h00, 32'h0, 32'h2, 1, 0, 0, 0, "R3 readback R5 code4");
        issue(3'd0, 3'b101, 3'd7, 3'd2, 8'hff, 32'h5555_aaaa, 32'hffff_fffe, 0, 0, 0, 0, "R5 code5");
        // R6/R7 immediates
        issue(3'd2, 3'b110, 3'd3, 3'd3, 8'hc7, 32'h1, 32'h8765_4321, 1, 0, 0, 0, "R6 imm8 code6");
        issue(3'd2, 3'b111, 3'd3, 3'd4, 8'h80, 32'h2, 32'hdead_beef, 1, 0, 0, 0, "R6 imm8 code7");
        issue(3'd5, 3'b110, 3'd3, 3'd5, 8'h01, 32'h4, 32'hf000_0000, 0, 0, 0, 0, "R7 neg imm32");
        issue(3'd5, 3'b111, 3'd3, 3'd6, 8'h01, 32'h8, 32'h0000_7fff, 0, 0, 0, 0, "R7 pos imm32");
        idle();
        // R9: collision, update wins; write to another register takes effect
        issue(3'd6, 3'b000, 3'd6, 3'd0, 8'h0, 32'h0000_00ff, 32'h0, 0, 1, 3'd6, 64'hbad0_bad0_bad0_bad0, "R9 collide");
        issue(3'd0, 3'b000, 3'd6, 3'd0, 8'h0, 32'h0, 32'h0, 0, 1, 3'd7, 64'h7777_8888_9999_aaaa, "R9 readback");
        issue(3'd0, 3'b000, 3'd7, 3'd0, 8'h0, 32'h0, 32'h0, 0, 0, 0, 0, "R9 other reg");
        // R10 hold and R11 quiet cycles
        idle();
        @(posedge clk); #1;
        hb = op_b; ha = rd_addr;
        repeat (3) @(negedge clk);
        chk(op_b == hb, "R10 op_b hold", op_b, hb);
        chk(rd_addr == ha, "R10 rd_addr hold", 64'(rd_addr), 64'(ha));
        for (int i = 0; i < 8; i++)
            issue(3'(i), 3'b000, 3'(i), 3'd0, 8'h0, 32'h0, 32'h0, 0, 0, 0, 0, "R11 regs unchanged");
        idle();
        repeat (3) @(negedge clk);
        chk(q.size() == 0, "R10 queue drained", 64'(q.size()), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule